// File: doc/BRIEF.md
# Dual-Output PWM Slice with Fractional Clock Divider

This block is one pulse-width-modulation slice. A 16-bit counter advances on a clock enable that a fractional divider makes from the system clock. The divider setting has eight integer bits and four fraction bits. Two outputs, A and B, each compare the counter against their own threshold. A write or read port gives software access to all settings:

- the slice enable, up/down (phase-correct) counting and per-output inversion;
- a one-count nudge of the counter forward or back;
- the divider setting, the counter itself, both thresholds and the wrap value;
- an interrupt flag with its enable and force bits.

Each counter period ends with a wrap event. The wrap event sets an interrupt flag. The flag, its enable bit and a force bit together drive the interrupt output. Software reads registers over the same port, with a combinational read of the addressed register. Only the free-running clocking mode is built. The mode field is kept, but its value does not change behaviour.

Register addresses (4-bit word address):

| Address | Register |
|---|---|
| 0 | control |
| 1 | divider |
| 2 | counter |
| 3 | thresholds |
| 4 | wrap value |
| 5 | interrupt flag |
| 6 | interrupt enable |
| 7 | interrupt force |
| 8 | interrupt status, read-only |

Control register bits:

| Bit | Meaning |
|---|---|
| 0 | run |
| 1 | up/down mode |
| 2 | invert A |
| 3 | invert B |
| 5:4 | mode field |
| 6 | retard request |
| 7 | advance request |

Other register fields:

| Register | Fields |
|---|---|
| Divider | integer part in bits 11:4, fraction in bits 3:0 |
| Thresholds | A threshold in bits 15:0, B threshold in bits 31:16 |
| Interrupt flag, enable, force | bit 0 only |

Top module: `pwm_slice`

## Requirements
- R1: Reset values:

  | Item | Value |
  |---|---|
  | Control register | 0 |
  | Divider | integer 1, fraction 0 (reads 0x010) |
  | Counter | 0 |
  | Both thresholds | 0 |
  | Wrap value | 0xFFFF |
  | Interrupt flag, enable and force | 0 |
  | pwm_a, pwm_b, irq | 0 |

- R2: In sawtooth mode (control bit 1 = 0), each divider tick moves the counter up by one. A tick taken at the wrap value sets the counter to 0 and raises a wrap event.
- R3: The divider value is D = 16·integer + fraction, and an integer part of 0 counts as 256. Starting from run, after k system clocks with no other writes the counter has taken floor(16·k/D) ticks. The first tick can come at the edge after the edge that sets run.
- R4: In up/down mode (control bit 1 = 1), the counter counts up to the wrap value, then down to 0, then up again. The wrap event comes on the tick that leaves 0 on the way up.
- R5: While running, output A equals (counter < A threshold) XOR invert-A, and B likewise with its own fields. A threshold above the wrap value keeps the compare true all the time.
- R6: With run = 0, the counter holds its value and each output sits at its invert bit.
- R7: A write with bit 7 set, made while running, makes the next tick step the counter twice. A write with bit 6 set, made while running, swallows the next tick. Both bits read back as 0. Such requests made while stopped are ignored.
- R8: A counter write loads the value on the next edge and takes priority over a tick in that cycle. Counting continues from the loaded value.
- R9: A wrap event sets the interrupt flag. Writing 1 to bit 0 of address 5 clears the flag, but a wrap in the same cycle wins.
- R10: irq and the status register equal (flag AND enable) OR force.
- R11: The 2-bit mode field reads back as written and does not change counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| irq | output | 1 | Interrupt status |

## Verification
The hardest cases to reach from the ports are timing coincidences:

- a phase nudge pending at the moment the counter turns or wraps, so that the double step crosses an end point;
- a flag clear written in the same cycle as a wrap;
- a divider change arriving while the accumulator holds a remainder.

Random writes keep the wrap value and dividers small, so turns and wraps happen every few clocks. They also issue advance and retard requests often, so these collisions come up many times. A cycle-level bench model, built from the requirements, checks both outputs, the interrupt and the counter after every clock. Directed sequences pin down the closed-form tick count, the up/down turn timing and each nudge.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;
  localparam int ADDR_W  = 4;
  localparam int NUM_OUT = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_DIV   = 4'd1;
  localparam logic [ADDR_W-1:0] A_COUNT = 4'd2;
  localparam logic [ADDR_W-1:0] A_CMP   = 4'd3;
  localparam logic [ADDR_W-1:0] A_WRAP  = 4'd4;
  localparam logic [ADDR_W-1:0] A_RAW   = 4'd5;
  localparam logic [ADDR_W-1:0] A_IEN   = 4'd6;
  localparam logic [ADDR_W-1:0] A_FORCE = 4'd7;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd8;

  localparam int CB_EN   = 0;
  localparam int CB_PC   = 1;
  localparam int CB_INVA = 2;
  localparam int CB_INVB = 3;
  localparam int CB_MODE = 4;
  localparam int CB_RET  = 6;
  localparam int CB_ADV  = 7;
endpackage

// File: rtl/pwm_frac_div.sv
module pwm_frac_div #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick
);
  localparam int DEN_W = INT_W + 1 + FRAC_W;
  localparam int ACC_W = DEN_W + 1;

  logic [DEN_W-1:0] den;
  logic [ACC_W-1:0] acc_q, acc_d, sum;

  always_comb begin
    den   = {(div_int == '0), div_int, div_frac};
    sum   = acc_q + ACC_W'(2 ** FRAC_W);
    tick  = run && (sum >= {1'b0, den});
    if (!run)      acc_d = '0;
    else if (tick) acc_d = sum - {1'b0, den};
    else           acc_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R3: a divisor of exactly one gives a tick on every running clock
  a_r3_unit_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (run && den == DEN_W'(2 ** FRAC_W)) |-> tick);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             pc_mode,
  input  logic [CNT_W-1:0] top,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             adv_req,
  input  logic             ret_req,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  typedef struct packed {
    logic             wrap;
    logic             down;
    logic [CNT_W-1:0] val;
  } step_t;

  function automatic step_t step_fn(logic [CNT_W-1:0] v, logic down,
                                    logic [CNT_W-1:0] t, logic pc);
    step_t r;
    r.wrap = 1'b0;
    r.down = down;
    r.val  = v;
    if (!pc) begin
      r.down = 1'b0;
      if (v == t) begin
        r.val  = '0;
        r.wrap = 1'b1;
      end else begin
        r.val = v + 1'b1;
      end
    end else if (!down) begin
      if (v >= t) begin
        if (t == '0) begin
          r.val  = '0;
          r.wrap = 1'b1;
        end else begin
          r.down = 1'b1;
          r.val  = v - 1'b1;
        end
      end else begin
        r.val = v + 1'b1;
      end
    end else begin
      if (v == '0) begin
        r.wrap = 1'b1;
        r.down = 1'b0;
        r.val  = (t == '0) ? '0 : CNT_W'(1);
      end else begin
        r.val = v - 1'b1;
      end
    end
    return r;
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             down_q, down_d;
  logic             adv_pend_q, adv_pend_d;
  logic             ret_pend_q, ret_pend_d;
  step_t            s1, s2;
  logic             fire, hold, move, dbl;

  always_comb begin
    s1   = step_fn(cnt_q, down_q, top, pc_mode);
    s2   = step_fn(s1.val, s1.down, top, pc_mode);
    fire = tick && !load;
    hold = fire && ret_pend_q;
    move = fire && !ret_pend_q;
    dbl  = move && adv_pend_q;

    if (load)      cnt_d = load_val;
    else if (move) cnt_d = dbl ? s2.val : s1.val;
    else           cnt_d = cnt_q;

    down_d     = move ? (dbl ? s2.down : s1.down) : down_q;
    wrap       = move && (s1.wrap || (adv_pend_q && s2.wrap));
    ret_pend_d = run && ((ret_pend_q && !hold) || ret_req);
    adv_pend_d = run && ((adv_pend_q && !dbl) || adv_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      down_q     <= 1'b0;
      adv_pend_q <= 1'b0;
      ret_pend_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      down_q     <= down_d;
      adv_pend_q <= adv_pend_d;
      ret_pend_q <= ret_pend_d;
    end
  end

  assign cnt = cnt_q;

  // R2: a plain sawtooth step at the wrap value lands on zero
  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (move && !pc_mode && !adv_pend_q && cnt_q == top) |=> (cnt_q == '0));

  // R4: the up/down counter turns at the wrap value
  a_r4_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (move && pc_mode && !adv_pend_q && !down_q && cnt_q == top && top != '0)
    |=> (down_q && cnt_q == $past(top) - CNT_W'(1)));

  // R7: a swallowed tick leaves the counter where it was
  a_r7_retard_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(cnt_q));

  // R6: a stopped counter without a load holds
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_out.sv
module pwm_out #(
  parameter int CNT_W = 16
) (
  input  logic             run,
  input  logic             inv,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] thresh,
  output logic             out
);
  always_comb begin
    if (run) out = (cnt < thresh) ^ inv;
    else     out = inv;
  end
endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
  import pwm_slice_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DIV_INT_W  = 8,
  parameter int DIV_FRAC_W = 4,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic              irq
);
  localparam int DIV_W = DIV_INT_W + DIV_FRAC_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  logic                            en_q, en_d, pc_q, pc_d;
  logic [NUM_OUT-1:0]              inv_q, inv_d;
  logic [1:0]                      mode_q, mode_d;
  logic [DIV_INT_W-1:0]            dint_q, dint_d;
  logic [DIV_FRAC_W-1:0]           dfrac_q, dfrac_d;
  logic [NUM_OUT-1:0][CNT_W-1:0]   cmp_q, cmp_d;
  logic [CNT_W-1:0]                top_q, top_d;
  logic                            raw_q, raw_d, ie_q, ie_d, frc_q, frc_d;

  logic             tick, wrap, load, adv_req, ret_req, status;
  logic [CNT_W-1:0] cnt;
  logic [NUM_OUT-1:0] outs;

  assign load    = reg_we && (reg_addr == A_COUNT);
  assign adv_req = reg_we && (reg_addr == A_CTRL) && reg_wdata[CB_ADV] && en_q;
  assign ret_req = reg_we && (reg_addr == A_CTRL) && reg_wdata[CB_RET] && en_q;

  always_comb begin
    en_d    = en_q;
    pc_d    = pc_q;
    inv_d   = inv_q;
    mode_d  = mode_q;
    dint_d  = dint_q;
    dfrac_d = dfrac_q;
    cmp_d   = cmp_q;
    top_d   = top_q;
    ie_d    = ie_q;
    frc_d   = frc_q;
    if (reg_we) begin
      case (reg_addr)
        A_CTRL: begin
          en_d   = reg_wdata[CB_EN];
          pc_d   = reg_wdata[CB_PC];
          inv_d  = {reg_wdata[CB_INVB], reg_wdata[CB_INVA]};
          mode_d = reg_wdata[CB_MODE +: 2];
        end
        A_DIV: begin
          dint_d  = reg_wdata[DIV_FRAC_W +: DIV_INT_W];
          dfrac_d = reg_wdata[DIV_FRAC_W-1:0];
        end
        A_CMP: begin
          cmp_d[0] = reg_wdata[CNT_W-1:0];
          cmp_d[1] = reg_wdata[2*CNT_W-1:CNT_W];
        end
        A_WRAP:  top_d = reg_wdata[CNT_W-1:0];
        A_IEN:   ie_d  = reg_wdata[0];
        A_FORCE: frc_d = reg_wdata[0];
        default: ;
      endcase
    end
    raw_d = (raw_q && !(reg_we && reg_addr == A_RAW && reg_wdata[0])) || wrap;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      en_q    <= 1'b0;
      pc_q    <= 1'b0;
      inv_q   <= '0;
      mode_q  <= '0;
      dint_q  <= DIV_INT_W'(1);
      dfrac_q <= '0;
      cmp_q   <= '0;
      top_q   <= '1;
      raw_q   <= 1'b0;
      ie_q    <= 1'b0;
      frc_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      pc_q    <= pc_d;
      inv_q   <= inv_d;
      mode_q  <= mode_d;
      dint_q  <= dint_d;
      dfrac_q <= dfrac_d;
      cmp_q   <= cmp_d;
      top_q   <= top_d;
      raw_q   <= raw_d;
      ie_q    <= ie_d;
      frc_q   <= frc_d;
    end
  end

  pwm_frac_div #(.INT_W(DIV_INT_W), .FRAC_W(DIV_FRAC_W)) u_div (
    .clk(clk), .rst_n(srst_n), .run(en_q),
    .div_int(dint_q), .div_frac(dfrac_q), .tick(tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(srst_n), .run(en_q), .tick(tick), .pc_mode(pc_q),
    .top(top_q), .load(load), .load_val(reg_wdata[CNT_W-1:0]),
    .adv_req(adv_req), .ret_req(ret_req), .cnt(cnt), .wrap(wrap)
  );

  for (genvar ch = 0; ch < NUM_OUT; ch++) begin : g_out
    pwm_out #(.CNT_W(CNT_W)) u_out (
      .run(en_q), .inv(inv_q[ch]), .cnt(cnt), .thresh(cmp_q[ch]), .out(outs[ch])
    );
  end

  assign status = (raw_q && ie_q) || frc_q;
  assign pwm_a  = outs[0];
  assign pwm_b  = outs[1];
  assign irq    = status;

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = DATA_W'({mode_q, inv_q[1], inv_q[0], pc_q, en_q});
      A_DIV:   reg_rdata = DATA_W'({dint_q, dfrac_q});
      A_COUNT: reg_rdata = DATA_W'(cnt);
      A_CMP:   reg_rdata = DATA_W'({cmp_q[1], cmp_q[0]});
      A_WRAP:  reg_rdata = DATA_W'(top_q);
      A_RAW:   reg_rdata = DATA_W'(raw_q);
      A_IEN:   reg_rdata = DATA_W'(ie_q);
      A_FORCE: reg_rdata = DATA_W'(frc_q);
      A_STAT:  reg_rdata = DATA_W'(status);
      default: reg_rdata = '0;
    endcase
  end

  // R9: a wrap event always leaves the flag set
  a_r9_raw_on_wrap: assert property (@(posedge clk) disable iff (!srst_n)
    wrap |=> raw_q);

  // R10: force drives the interrupt regardless of the flag
  a_r10_force: assert property (@(posedge clk) disable iff (!srst_n)
    frc_q |-> irq);

  // R6: a stopped slice shows the invert levels
  a_r6_idle_level: assert property (@(posedge clk) disable iff (!srst_n)
    !en_q |-> (pwm_a == inv_q[0] && pwm_b == inv_q[1]));

  // R5: a threshold above the wrap value keeps the compare true
  a_r5_above_top: assert property (@(posedge clk) disable iff (!srst_n)
    (en_q && cmp_q[0] > top_q && cnt <= top_q) |-> (pwm_a != inv_q[0]));

  logic unused_w;
  assign unused_w = ^{DIV_W, 1'b0};
endmodule

// File: tb/pwm_slice_bench.sv
module pwm_slice_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        pwm_a, pwm_b, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  pwm_slice u_pwm_slice (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .irq(irq)
  );

  // requirement-level reference model
  bit        m_en, m_pc, m_ia, m_ib, m_down, m_raw, m_ie, m_frc, m_adv, m_ret;
  bit [1:0]  m_mode;
  bit [7:0]  m_int;
  bit [3:0]  m_frac;
  bit [15:0] m_cnt, m_ca, m_cb, m_top;
  int        m_acc;

  task automatic m_reset();
    m_en = 0; m_pc = 0; m_ia = 0; m_ib = 0; m_down = 0; m_raw = 0; m_ie = 0;
    m_frc = 0; m_adv = 0; m_ret = 0; m_mode = 0; m_int = 8'd1; m_frac = 0;
    m_cnt = 0; m_ca = 0; m_cb = 0; m_top = 16'hFFFF; m_acc = 0;
  endtask

  task automatic m_step(output bit w);
    w = 0;
    if (!m_pc) begin
      m_down = 0;
      if (m_cnt == m_top) begin m_cnt = 0; w = 1; end
      else m_cnt = m_cnt + 16'd1;
    end else if (!m_down) begin
      if (m_cnt >= m_top) begin
        if (m_top == 0) begin m_cnt = 0; w = 1; end
        else begin m_down = 1; m_cnt = m_cnt - 16'd1; end
      end else m_cnt = m_cnt + 16'd1;
    end else begin
      if (m_cnt == 0) begin w = 1; m_down = 0; m_cnt = (m_top == 0) ? 16'd0 : 16'd1; end
      else m_cnt = m_cnt - 16'd1;
    end
  endtask

  task automatic m_clock(bit we, logic [3:0] a, logic [31:0] d);
    int den;
    bit tk, w1, w2, ld, areq, rreq, oadv, oret;
    den  = ((m_int == 0) ? 256 : int'(m_int)) * 16 + int'(m_frac);
    tk   = m_en && (m_acc + 16 >= den);
    ld   = we && a == 4'd2;
    areq = we && a == 4'd0 && d[7] && m_en;
    rreq = we && a == 4'd0 && d[6] && m_en;
    oadv = m_adv; oret = m_ret; w1 = 0; w2 = 0;
    m_acc = !m_en ? 0 : (tk ? m_acc + 16 - den : m_acc + 16);
    if (ld) m_cnt = d[15:0];
    else if (tk) begin
      if (oret) m_ret = 0;
      else begin
        m_step(w1);
        if (oadv) begin m_step(w2); m_adv = 0; end
      end
    end
    if (!m_en) begin m_adv = 0; m_ret = 0; end
    else begin m_adv = m_adv | areq; m_ret = m_ret | rreq; end
    m_raw = (m_raw && !(we && a == 4'd5 && d[0])) || w1 || w2;
    if (we) begin
      case (a)
        4'd0: begin m_en = d[0]; m_pc = d[1]; m_ia = d[2]; m_ib = d[3]; m_mode = d[5:4]; end
        4'd1: begin m_int = d[11:4]; m_frac = d[3:0]; end
        4'd3: begin m_ca = d[15:0]; m_cb = d[31:16]; end
        4'd4: m_top = d[15:0];
        4'd6: m_ie = d[0];
        4'd7: m_frc = d[0];
        default: ;
      endcase
    end
  endtask

  function automatic bit exp_out(bit inv, bit [15:0] th);
    return m_en ? ((m_cnt < th) ^ inv) : inv;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic cmp_all();
    logic [31:0] v;
    check(cur_req, "pwm_a", 32'(pwm_a), 32'(exp_out(m_ia, m_ca)));
    check(cur_req, "pwm_b", 32'(pwm_b), 32'(exp_out(m_ib, m_cb)));
    check(cur_req, "irq (R10)", 32'(irq), 32'((m_raw && m_ie) || m_frc));
    rd(4'd2, v);
    check(cur_req, "counter", v, 32'(m_cnt));
  endtask

  task automatic cyc(bit we, logic [3:0] a, logic [31:0] d);
    reg_we = we; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    m_clock(we, a, d);
    @(negedge clk);
    reg_we = 1'b0;
    cmp_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, 32'd0);
  endtask

  function automatic logic [31:0] rand_data(logic [3:0] a);
    logic [31:0] d;
    d = 32'd0;
    case (a)
      4'd0: begin
        d[0] = ($urandom_range(0, 3) != 0);
        d[1] = $urandom_range(0, 1) == 1;
        d[2] = $urandom_range(0, 1) == 1;
        d[3] = $urandom_range(0, 1) == 1;
        d[5:4] = 2'($urandom_range(0, 3));
        d[6] = ($urandom_range(0, 3) == 0);
        d[7] = ($urandom_range(0, 3) == 0);
      end
      4'd1: d = {20'd0, 8'($urandom_range(0, 3)), 4'($urandom_range(0, 15))};
      4'd2: d = 32'($urandom_range(0, 50));
      4'd3: d = {16'($urandom_range(0, 45)), 16'($urandom_range(0, 45))};
      4'd4: d = 32'($urandom_range(0, 40));
      default: d = 32'($urandom_range(0, 1));
    endcase
    return d;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c0;
    void'($urandom(32'd2718));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset values
    cur_req = "R1";
    rd(4'd0, v); check("R1", "ctrl", v, 32'h0);
    rd(4'd1, v); check("R1", "div", v, 32'h010);
    rd(4'd2, v); check("R1", "counter", v, 32'h0);
    rd(4'd3, v); check("R1", "thresholds", v, 32'h0);
    rd(4'd4, v); check("R1", "wrap value", v, 32'hFFFF);
    rd(4'd5, v); check("R1", "flag", v, 32'h0);
    rd(4'd6, v); check("R1", "enable", v, 32'h0);
    rd(4'd7, v); check("R1", "force", v, 32'h0);
    check("R1", "outputs", {29'd0, pwm_a, pwm_b, irq}, 32'h0);

    // R2: sawtooth with small wrap value
    cur_req = "R2";
    cyc(1, 4'd4, 32'd9);
    cyc(1, 4'd3, {16'd7, 16'd4});
    cyc(1, 4'd0, 32'h1);
    idle(25);

    // R3: closed-form tick count, divider 2 + 8/16
    cur_req = "R3";
    cyc(1, 4'd0, 32'h0);
    cyc(1, 4'd4, 32'hFFFF);
    cyc(1, 4'd2, 32'd0);
    cyc(1, 4'd1, {20'd0, 8'd2, 4'd8});
    cyc(1, 4'd0, 32'h1);
    idle(100);
    rd(4'd2, v); check("R3", "ticks D=40 k=100", v, 32'd40);
    // integer part 0 counts as 256
    cyc(1, 4'd0, 32'h0);
    cyc(1, 4'd2, 32'd0);
    cyc(1, 4'd1, 32'h000);
    cyc(1, 4'd0, 32'h1);
    idle(300);
    rd(4'd2, v); check("R3", "ticks D=4096 k=300", v, 32'd1);

    // R4: up/down mode, wrap on leaving zero
    cur_req = "R4";
    cyc(1, 4'd0, 32'h0);
    cyc(1, 4'd5, 32'h1);
    cyc(1, 4'd1, 32'h010);
    cyc(1, 4'd2, 32'd0);
    cyc(1, 4'd4, 32'd5);
    cyc(1, 4'd3, {16'd2, 16'd3});
    cyc(1, 4'd0, 32'h3);
    idle(10);
    rd(4'd2, v); check("R4", "count after 10", v, 32'd0);
    rd(4'd5, v); check("R4", "no wrap yet", v, 32'd0);
    idle(1);
    rd(4'd2, v); check("R4", "count after 11", v, 32'd1);
    rd(4'd5, v); check("R4", "wrap on leaving 0", v, 32'd1);
    idle(20);

    // R9: clear by writing one
    cur_req = "R9";
    cyc(1, 4'd5, 32'h1);
    rd(4'd5, v); check("R9", "flag cleared", v, 32'd0);
    idle(15);
    rd(4'd5, v); check("R9", "flag set again", v, 32'd1);

    // R10: enable and force
    cur_req = "R10";
    cyc(1, 4'd6, 32'h1);
    check("R10", "irq flag&enable", 32'(irq), 32'd1);
    cyc(1, 4'd6, 32'h0);
    check("R10", "irq masked", 32'(irq), 32'd0);
    cyc(1, 4'd7, 32'h1);
    rd(4'd8, v); check("R10", "status forced", v, 32'd1);
    cyc(1, 4'd7, 32'h0);

    // R5: threshold above wrap, inversion
    cur_req = "R5";
    cyc(1, 4'd3, {16'd0, 16'd20});
    cyc(1, 4'd0, 32'h9);
    idle(12);
    check("R5", "A above top high", 32'(pwm_a), 32'd1);
    check("R5", "B zero thresh inverted", 32'(pwm_b), 32'd1);

    // R6: stopped slice
    cur_req = "R6";
    cyc(1, 4'd0, 32'h4);
    rd(4'd2, c0);
    idle(6);
    rd(4'd2, v); check("R6", "counter held", v, c0);
    check("R6", "A at invert", 32'(pwm_a), 32'd1);
    check("R6", "B at invert", 32'(pwm_b), 32'd0);

    // R7: advance and retard
    cur_req = "R7";
    cyc(1, 4'd4, 32'hFFFF);
    cyc(1, 4'd0, 32'h1);
    rd(4'd2, c0);
    cyc(1, 4'd0, 32'h81);
    cyc(0, 4'd0, 32'h0);
    rd(4'd2, v); check("R7", "advance adds one", v, c0 + 32'd3);
    rd(4'd0, v); check("R7", "request bits read 0", v, 32'h1);
    rd(4'd2, c0);
    cyc(1, 4'd0, 32'h41);
    cyc(0, 4'd0, 32'h0);
    cyc(0, 4'd0, 32'h0);
    rd(4'd2, v); check("R7", "retard drops one", v, c0 + 32'd2);
    cyc(1, 4'd0, 32'h0);
    cyc(1, 4'd0, 32'h80);
    rd(4'd2, c0);
    cyc(1, 4'd0, 32'h1);
    cyc(0, 4'd0, 32'h0);
    cyc(0, 4'd0, 32'h0);
    rd(4'd2, v); check("R7", "stopped request ignored", v, c0 + 32'd2);

    // R8: load wins over a tick
    cur_req = "R8";
    cyc(1, 4'd2, 32'd100);
    rd(4'd2, v); check("R8", "loaded", v, 32'd100);
    cyc(0, 4'd0, 32'h0);
    rd(4'd2, v); check("R8", "continues", v, 32'd101);

    // R11: mode field stored, no effect
    cur_req = "R11";
    cyc(1, 4'd0, 32'h31);
    rd(4'd0, v); check("R11", "mode readback", v, 32'h31);
    idle(10);

    // random mix: R2 R3 R4 R5 R7 R9 R10 all compared by the model
    cur_req = "R9 random";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 5) == 0) begin
        logic [3:0] a;
        a = 4'($urandom_range(0, 8));
        cyc(1, a, rand_data(a));
      end else begin
        cyc(0, 4'd0, 32'd0);
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule